// File: doc/BRIEF.md
# Span Colour and Depth Interpolator

This block generates the pixels of one horizontal span. A host first writes start values and per-pixel slopes for red, green, blue and depth, a base pixel address, a signed pixel count and a control word. It then pulses `start`. The block emits one pixel per accepted handshake. Each pixel carries the stepped colour, the stepped depth, a frame-buffer address and a write enable.

The write enable combines two gates. The first is a depth test of the new depth against the stored depth, which the consumer presents on `old_z` alongside each pixel. The second is a 16-bit screen-door pattern indexed by pixel position. Colour and depth stepping can each be frozen. Address stepping can be turned off. Depth resolution is either 16 or 24 integer bits. A pseudo-colour mode keeps only the blue channel. After the last pixel is accepted, `done` pulses for one cycle.

Top module: `span_interp`

## Requirements
- R1: The count register (select 1, bits 12:0) is a two's-complement 13-bit value. A start with a count of zero or less produces no pixel, and `done` is high in the cycle after the start edge.
- R2: A start with count N>0 produces exactly N pixels, and `px_valid` stays high until the Nth handshake. While a pixel is stalled (`px_ready` low), its colour, depth and address hold.
- R3: Each colour start value is unsigned 8.12 fixed point. Each slope is signed 8.12, sign bit 19. Pixel i carries start + i*slope. The output is the integer part, clamped to 0 when negative and to 255 when above 255. Selects: red 5/6, green 7/8, blue 9/10 (start/slope).
- R4: Control bit 17 set keeps every colour at its start value for the whole span.
- R5: Depth (select 3) and its slope (select 4) are 36-bit values with a 12-bit fraction, and pixel i carries start + i*slope modulo 2^36. With control bit 20 set, `px_z` is bits 35:12. Otherwise `px_z` is bits 27:12, zero-extended, so the value wraps at 16 integer bits.
- R6: Control bit 16 set keeps depth at its start value for the whole span.
- R7: Control bits 21, 22 and 23 enable pass on new<old, new>old and new==old respectively. The comparison uses `px_z` against `old_z`; in 16-bit mode only the low 16 bits of `old_z` are used. With no enabled relation true, `px_we` is low.
- R8: Control bits 15:0 are the screen-door pattern. Pixel i may be written only if pattern bit (i mod 16) is 1.
- R9: Pixel i has address base + i modulo 2^24, with the base at select 2. With control bit 18 set, every pixel uses the base address.
- R10: With control bit 19 set, `px_r` and `px_g` are 0 and blue is unaffected.
- R11: `done` is high for exactly the one cycle after the last handshake, with `px_valid` low. A start pulse during a span is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_data | input | 36 | Register write data |
| start | input | 1 | Begin a span (ignored while busy) |
| old_z | input | 24 | Stored depth for the current pixel |
| px_ready | input | 1 | Consumer accepts the current pixel |
| px_valid | output | 1 | A pixel is presented |
| px_r | output | 8 | Red integer part |
| px_g | output | 8 | Green integer part |
| px_b | output | 8 | Blue integer part |
| px_z | output | 24 | New depth integer part |
| px_we | output | 1 | Pixel passes depth test and screen door |
| px_addr | output | 24 | Pixel address |
| done | output | 1 | One-cycle pulse after the span ends |

## Verification
The in-line assertions guard several properties on every cycle: output hold during a stall, the empty-span done response, address hold when stepping is off, gating of writes by the screen door, and the zeroing of red and green in pseudo-colour mode. The arithmetic needs the bench's scenarios, which compare against models of the fixed-point sums. These cover saturation at both ends, 16-bit depth wrap, the depth relations with `old_z` forced near equality, and exact pixel counts including negative counts and a start pulse issued mid-span.

// File: rtl/span_interp.sv
module span_interp #(
  parameter int CNT_W = 13,
  parameter int CI    = 8,
  parameter int CF    = 12,
  parameter int ZI    = 24,
  parameter int ZI_LO = 16,
  parameter int AW    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_sel,
  input  logic [ZI+CF-1:0] cfg_data,
  input  logic             start,
  input  logic [ZI-1:0]    old_z,
  input  logic             px_ready,
  output logic             px_valid,
  output logic [CI-1:0]    px_r,
  output logic [CI-1:0]    px_g,
  output logic [CI-1:0]    px_b,
  output logic [ZI-1:0]    px_z,
  output logic             px_we,
  output logic [AW-1:0]    px_addr,
  output logic             done
);
  localparam int CW   = CI + CF;
  localparam int CACC = CW + CNT_W;
  localparam int ZW   = ZI + CF;

  logic [23:0]       ctrl;
  logic [CNT_W-1:0]  span_cnt;
  logic [AW-1:0]     base;
  logic [ZW-1:0]     z0, dz, zacc;
  logic [CW-1:0]     cst [3];
  logic [CW-1:0]     csl [3];
  logic signed [CACC-1:0] cacc [3];
  logic              busy;
  logic [CNT_W-1:0]  rem;
  logic [3:0]        idx;

  wire z_hold  = ctrl[16];
  wire c_hold  = ctrl[17];
  wire a_hold  = ctrl[18];
  wire pseudo  = ctrl[19];
  wire z_wide  = ctrl[20];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; span_cnt <= '0; base <= '0; z0 <= '0; dz <= '0;
      for (int k = 0; k < 3; k++) begin cst[k] <= '0; csl[k] <= '0; end
    end else if (cfg_we) begin
      case (cfg_sel)
        4'd0:  ctrl     <= cfg_data[23:0];
        4'd1:  span_cnt <= cfg_data[CNT_W-1:0];
        4'd2:  base     <= cfg_data[AW-1:0];
        4'd3:  z0       <= cfg_data;
        4'd4:  dz       <= cfg_data;
        4'd5:  cst[0]   <= cfg_data[CW-1:0];
        4'd6:  csl[0]   <= cfg_data[CW-1:0];
        4'd7:  cst[1]   <= cfg_data[CW-1:0];
        4'd8:  csl[1]   <= cfg_data[CW-1:0];
        4'd9:  cst[2]   <= cfg_data[CW-1:0];
        4'd10: csl[2]   <= cfg_data[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rem <= '0; idx <= '0; zacc <= '0; px_addr <= '0;
      for (int k = 0; k < 3; k++) cacc[k] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if ($signed(span_cnt) > 0) begin
            busy    <= 1'b1;
            rem     <= span_cnt;
            idx     <= '0;
            zacc    <= z0;
            px_addr <= base;
            for (int k = 0; k < 3; k++) cacc[k] <= {{CNT_W{1'b0}}, cst[k]};
          end else begin
            done <= 1'b1;
          end
        end
      end else if (px_ready) begin
        if (rem == 1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rem <= rem - 1'b1;
          idx <= idx + 1'b1;
          if (!z_hold) zacc <= zacc + dz;
          if (!a_hold) px_addr <= px_addr + 1'b1;
          if (!c_hold)
            for (int k = 0; k < 3; k++) cacc[k] <= cacc[k] + {{CNT_W{csl[k][CW-1]}}, csl[k]};
        end
      end
    end
  end

  function automatic logic [CI-1:0] sat(input logic signed [CACC-1:0] a);
    if (a < 0) return '0;
    if (a[CACC-2:CF+CI] != '0) return '1;
    return a[CF+CI-1:CF];
  endfunction

  logic [ZI-1:0] oz;
  logic lt, gt, eq;

  assign px_valid = busy;
  assign px_r = pseudo ? '0 : sat(cacc[0]);
  assign px_g = pseudo ? '0 : sat(cacc[1]);
  assign px_b = sat(cacc[2]);
  assign px_z = z_wide ? zacc[ZW-1:CF] : {{(ZI-ZI_LO){1'b0}}, zacc[CF+ZI_LO-1:CF]};
  assign oz   = z_wide ? old_z : {{(ZI-ZI_LO){1'b0}}, old_z[ZI_LO-1:0]};
  assign lt   = ctrl[21] && (px_z < oz);
  assign gt   = ctrl[22] && (px_z > oz);
  assign eq   = ctrl[23] && (px_z == oz);
  assign px_we = busy && ctrl[idx] && (lt || gt || eq);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready && !cfg_we |=> px_valid && $stable(px_addr) && $stable(px_z) && $stable(px_b));
  a_r1_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    start && !px_valid && ($signed(span_cnt) <= 0) && !cfg_we |=> done && !px_valid);
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && px_ready && a_hold && !cfg_we |=> $stable(px_addr));
  a_r8_door_gate: assert property (@(posedge clk) disable iff (!rst_n)
    px_we |-> px_valid && ctrl[idx]);
  a_r10_pseudo: assert property (@(posedge clk) disable iff (!rst_n)
    pseudo |-> px_r == '0 && px_g == '0);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !px_valid);
endmodule

// File: tb/span_interp_test.sv
module span_interp_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, start = 0, px_ready = 0;
  logic [3:0] cfg_sel = 0;
  logic [35:0] cfg_data = 0;
  logic [23:0] old_z = 0;
  logic px_valid, px_we, done;
  logic [7:0] px_r, px_g, px_b;
  logic [23:0] px_z, px_addr;

  span_interp uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .start(start), .old_z(old_z), .px_ready(px_ready),
    .px_valid(px_valid), .px_r(px_r), .px_g(px_g), .px_b(px_b), .px_z(px_z),
    .px_we(px_we), .px_addr(px_addr), .done(done));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [23:0] ctrl;
  logic [12:0] cnt;
  logic [23:0] base;
  logic [35:0] z0, dz;
  logic [19:0] cs [3];
  logic [19:0] cl [3];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [35:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = 4'(sel); cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load();
    wr(0, {12'd0, ctrl}); wr(1, {23'd0, cnt}); wr(2, {12'd0, base});
    wr(3, z0); wr(4, dz);
    for (int k = 0; k < 3; k++) begin wr(5 + 2*k, {16'd0, cs[k]}); wr(6 + 2*k, {16'd0, cl[k]}); end
  endtask

  function automatic int ecol(int k, int i);
    longint v = longint'(cs[k]) + (ctrl[17] ? 0 : longint'(i) * longint'($signed(cl[k])));
    if (v < 0) return 0;
    v = v >>> 12;
    return (v > 255) ? 255 : int'(v);
  endfunction

  function automatic logic [23:0] ez(int i);
    logic [35:0] v = z0 + (ctrl[16] ? 36'd0 : 36'(i) * dz);
    return ctrl[20] ? v[35:12] : {8'd0, v[27:12]};
  endfunction

  function automatic bit ewe(int i, logic [23:0] z, logic [23:0] oz_in);
    logic [23:0] oz = ctrl[20] ? oz_in : {8'd0, oz_in[15:0]};
    bit m = (ctrl[21] && z < oz) || (ctrl[22] && z > oz) || (ctrl[23] && z == oz);
    return ctrl[i % 16] && m;
  endfunction

  task automatic run_span(input bit mid);
    int n = int'($signed(cnt));
    int i = 0;
    load();
    @(negedge clk); start = 1;
    if (n <= 0) begin
      @(negedge clk); start = 0; #1;
      chk(done && !px_valid, "R1 empty done", {done, px_valid}, 2'b10);
      @(negedge clk); #1;
      chk(!done && !px_valid, "R1 no pixels", {done, px_valid}, 2'b00);
      return;
    end
    while (i < n) begin
      logic [23:0] z;
      int pick;
      @(negedge clk);
      start = mid && (i == 2);
      px_ready = ($urandom % 4) != 0;
      z = ez(i);
      pick = $urandom % 4;
      old_z = (pick == 0) ? z - 1 : (pick == 1) ? z : (pick == 2) ? z + 1 : 24'($urandom);
      #1;
      chk(px_valid && !done, "R2 valid during span", {px_valid, done}, 2'b10);
      if (px_valid && px_ready) begin
        chk(px_r == (ctrl[19] ? 0 : ecol(0, i)), "R3/R4/R10 red", px_r, ctrl[19] ? 0 : ecol(0, i));
        chk(px_g == (ctrl[19] ? 0 : ecol(1, i)), "R3/R4/R10 green", px_g, ctrl[19] ? 0 : ecol(1, i));
        chk(px_b == ecol(2, i), "R3/R4 blue", px_b, ecol(2, i));
        chk(px_z == z, "R5/R6 depth", px_z, z);
        chk(px_we == ewe(i, z, old_z), "R7/R8 write enable", px_we, ewe(i, z, old_z));
        chk(px_addr == base + (ctrl[18] ? 24'd0 : 24'(i)), "R9 address", px_addr,
            base + (ctrl[18] ? 24'd0 : 24'(i)));
        i++;
      end
    end
    @(negedge clk); start = 0; px_ready = 0; #1;
    chk(done && !px_valid, "R11 done after last", {done, px_valid}, 2'b10);
    @(negedge clk); #1;
    chk(!done && !px_valid, "R2 exact count / R11 one-cycle done", {done, px_valid}, 2'b00);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(!px_valid && !done && px_addr == 0, "reset state", {px_valid, done}, 0);
    rst_n = 1;

    ctrl = 24'h20FFFF; base = 24'h100; z0 = 36'h0000_1000; dz = 36'h1000;
    cs[0] = 20'h10000; cs[1] = 20'h20000; cs[2] = 20'h30000;
    cl[0] = 20'h01000; cl[1] = 20'h01000; cl[2] = 20'h01000;
    cnt = 13'd0;       run_span(0);   // R1 zero
    cnt = 13'h1FFB;    run_span(0);   // R1 negative

    cnt = 13'd10; ctrl = 24'hA0FFFF;  // R3 saturation both ends, R7 less
    cs[0] = 20'hFA000; cl[0] = 20'h01000;
    cs[1] = 20'h03000; cl[1] = 20'hFF000;
    run_span(0);

    ctrl = 24'h4A5A5A; cnt = 13'd20; // R10 pseudo, R8 pattern, R7 greater
    run_span(0);

    ctrl = 24'hE7FFFF; cnt = 13'd6;  // R4 R6 R9 holds, all relations
    run_span(0);

    ctrl = 24'h80FFFF; z0 = 36'h0_FFFE_000; dz = 36'h1000; cnt = 13'd5; // R5 16-bit wrap
    run_span(0);
    ctrl = 24'h90FFFF; run_span(0);   // R5 24-bit no wrap

    ctrl = 24'h60FFFF; cnt = 13'd8; run_span(1); // R11 mid-span start ignored

    for (int s = 0; s < 30; s++) begin
      ctrl = 24'($urandom);
      cnt  = 13'(1 + $urandom % 40);
      base = 24'($urandom);
      z0   = {4'($urandom), 32'($urandom)};
      dz   = 36'($signed(18'($urandom)));
      for (int k = 0; k < 3; k++) begin
        cs[k] = 20'($urandom);
        cl[k] = 20'($signed(15'($urandom)));
      end
      run_span(s % 7 == 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule